// File: doc/BRIEF.md
# Bus-Mapped Dual 8-Bit Parallel I/O Adapter

This block attaches two 8-bit general-purpose ports to an 8-bit processor bus with a 16-bit address. Each port has an output-level register and a direction register. A 1 in a direction bit turns the matching pin into an output that drives the stored level. A 0 leaves the pin as an input, and its level is sampled on every clock edge. Software reads the port data register and gets a per-bit mix: the stored level for output pins and the sampled level for input pins.

The block also contains the address-decode glue that places it in the address space next to a ROM. Two chip selects must both be asserted to enable the adapter. The active-high select is taken from address bit 14 and the active-low select from address bit 15, so the adapter answers in the range 0x4000–0x7FFF. Its sixteen register slots repeat every 16 bytes across that range. The ROM enable is the inverse of bit 15 and is active low, so the ROM owns 0x8000–0xFFFF. Only register slots 0 to 3 are populated. The other twelve slots read as zero and discard writes.

Top module: `dual_port_io`

## Requirements
- R1: The adapter is selected only when addr[14]=1 and addr[15]=0. A bus write outside 0x4000–0x7FFF changes no port register.
- R2: rom_ce_n equals the inverse of addr[15], so it is low exactly for 0x8000–0xFFFF. rom_ce_n is never low while rdata_oe is high.
- R3: The register slot is chosen by addr[3:0] alone. Every address in 0x4000–0x7FFF with the same low nibble reaches the same register.
- R4: Slot 3 is the Port A direction register. After a write, pa_oe equals the written byte from the next clock edge on.
- R5: Slot 1 is the Port A output register. After a write, pa_out equals the written byte from the next clock edge on.
- R6: Slot 0 is the Port B output register and slot 2 is the Port B direction register. They drive pb_out and pb_oe in the same way.
- R7: A register changes only at a rising clk edge with the adapter selected and rw=0. A cycle with rw=1 changes nothing.
- R8: A synchronous reset (rst_n low at a clock edge) clears both output registers, both direction registers and the sampled pin levels. Every pin then starts as an input driving 0.
- R9: Reading slot 1 or slot 0 returns, for each bit, the stored output bit where the direction bit is 1. Where the direction bit is 0, it returns the pin level captured at the previous clock edge.
- R10: Reading slot 3 or slot 2 returns the stored direction byte.
- R11: rdata_oe is high exactly while the adapter is selected and rw=1. rdata is 0x00 whenever rdata_oe is low.
- R12: Slots 4 to 15 read as 0x00. A write to any of them leaves every port output and direction unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus phase clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Processor address |
| rw | input | 1 | 1 = read cycle, 0 = write cycle |
| wdata | input | 8 | Write data from the processor |
| rdata | output | 8 | Read data toward the processor, zero when not driving |
| rdata_oe | output | 1 | Read-data drive enable for the shared data bus |
| rom_ce_n | output | 1 | Active-low ROM enable from the decode glue |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A driven levels |
| pa_oe | output | 8 | Port A per-pin output enables (direction) |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B driven levels |
| pb_oe | output | 8 | Port B per-pin output enables (direction) |

## Verification
The bench first runs the short program that sets every Port A pin to output and then alternates two patterns on it. This shows that slots 3 and 1 are wired to the right registers. Next, the same slots are reached through mirrored addresses near the top of the I/O range, which shows that only the low nibble picks the register. Writes are then aimed at ROM space, at low space and at slots 4–15, and the port pins must stay the same; this separates correct decoding from decoding that is too loose. A long random stream of mixed reads and writes follows, with changing pin levels and partial direction masks. It compares every read against a model of the input/output bit mix and of the one-edge pin sampling delay.

// File: rtl/pio_pkg.sv
// Package: shared constants for the dual-port I/O adapter.
// Assumes a four-bit register select; slots 0..3 hold the two ports'
// output and direction registers and all other slots are empty.
package pio_pkg;
    localparam int REG_SEL_W = 4;

    typedef enum logic [REG_SEL_W-1:0] {
        SLOT_PB_LEVEL = 4'd0,
        SLOT_PA_LEVEL = 4'd1,
        SLOT_PB_DIR   = 4'd2,
        SLOT_PA_DIR   = 4'd3
    } slot_e;
endpackage

// File: rtl/pio_addr_decode.sv
// Module: address-decode glue. It turns the processor address into the
// adapter's two chip selects, the ROM enable and the register slot index.
// Assumes the select bits are single address lines wired directly.
module pio_addr_decode #(
    parameter int ADDR_W     = 16,
    parameter int HI_SEL_BIT = 14,
    parameter int LO_SEL_BIT = 15,
    parameter int ROM_BIT    = 15,
    parameter int SEL_W      = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              cs_hi,
    output logic              cs_lo_n,
    output logic              rom_ce_n,
    output logic [SEL_W-1:0]  reg_idx
);
    // Direct wiring of address lines to selects and slot index.
    always_comb begin
        cs_hi    = addr[HI_SEL_BIT];
        cs_lo_n  = addr[LO_SEL_BIT];
        rom_ce_n = ~addr[ROM_BIT];
        reg_idx  = addr[SEL_W-1:0];
    end

    // The adapter and the ROM must never both be enabled.
    always_comb begin
        assert_rom_exclusive_R2: assert (!(cs_hi && !cs_lo_n && !rom_ce_n))
            else $error("adapter and ROM enabled together");
    end
endmodule

// File: rtl/pio_port.sv
// Module: one 8-bit port with an output-level register, a direction
// register and a register that samples the input pins.
// Assumes wr_en is already qualified by chip select and rw=0.
module pio_port #(
    parameter int W        = 8,
    parameter int SEL_W    = 4,
    parameter int DATA_OFS = 0,
    parameter int DIR_OFS  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] reg_idx,
    input  logic [W-1:0]     wdata,
    input  logic [W-1:0]     pin_in,
    output logic [W-1:0]     pin_out,
    output logic [W-1:0]     pin_oe,
    output logic             rd_hit,
    output logic [W-1:0]     rd_val
);
    localparam logic [SEL_W-1:0] DATA_IDX = DATA_OFS[SEL_W-1:0];
    localparam logic [SEL_W-1:0] DIR_IDX  = DIR_OFS[SEL_W-1:0];

    logic [W-1:0] level_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] smp_q;
    logic         hit_level;
    logic         hit_dir;

    // Slot match for this port's two registers.
    always_comb begin
        hit_level = (reg_idx == DATA_IDX);
        hit_dir   = (reg_idx == DIR_IDX);
    end

    // Output-level register: cleared on reset, loaded by a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_q <= '0;
        else if (wr_en && hit_level)
            level_q <= wdata;
    end

    // Direction register: cleared on reset (all inputs), loaded by a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= '0;
        else if (wr_en && hit_dir)
            dir_q <= wdata;
    end

    // Input sampling register: captures the pin levels on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            smp_q <= '0;
        else
            smp_q <= pin_in;
    end

    // Pin drive and read-back value (stored level on outputs, sample on inputs).
    always_comb begin
        pin_out = level_q;
        pin_oe  = dir_q;
        rd_hit  = hit_level | hit_dir;
        rd_val  = hit_dir ? dir_q : ((level_q & dir_q) | (smp_q & ~dir_q));
    end

    // The level register holds unless a write hits its slot.
    assert_level_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && hit_level) |=> $stable(pin_out))
        else $error("level register changed without a write");

    // The direction register holds unless a write hits its slot.
    assert_dir_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && hit_dir) |=> $stable(pin_oe))
        else $error("direction register changed without a write");

    // A write to the direction slot shows on the output enables at the next edge.
    assert_dir_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_dir) |=> (pin_oe == $past(wdata)))
        else $error("direction write not applied");
endmodule

// File: rtl/pio_bus_if.sv
// Module: bus-side logic. It combines the chip selects, qualifies writes
// and merges the ports' read values into one data bus that is zero when
// the adapter is not driving.
// Assumes port p owns slot p (level) and slot p+NPORT (direction).
module pio_bus_if #(
    parameter int W     = 8,
    parameter int NPORT = 2,
    parameter int SEL_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_hi,
    input  logic                      cs_lo_n,
    input  logic                      rw,
    input  logic [SEL_W-1:0]          reg_idx,
    input  logic [NPORT-1:0]          rd_hit,
    input  logic [NPORT-1:0][W-1:0]   rd_val,
    output logic                      wr_en,
    output logic [W-1:0]              rdata,
    output logic                      rdata_oe
);
    localparam int MAPPED = 2 * NPORT;

    logic selected;

    // Both chip selects must be active; then rw picks read or write.
    always_comb begin
        selected = cs_hi & ~cs_lo_n;
        wr_en    = selected & ~rw;
        rdata_oe = selected & rw;
    end

    // OR-merge of the hitting port's value, gated by the drive enable.
    always_comb begin
        rdata = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (rd_hit[p])
                rdata = rdata | rd_val[p];
        end
        if (!rdata_oe)
            rdata = '0;
    end

    // Empty slots read as zero.
    assert_empty_slot_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_oe && (int'(reg_idx) >= MAPPED)) |-> (rdata == '0))
        else $error("empty slot returned data");

    // No port may claim an empty slot.
    assert_empty_slot_no_hit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(reg_idx) >= MAPPED) |-> (rd_hit == '0))
        else $error("port claimed an empty slot");

    // At most one port answers any slot.
    assert_single_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_hit))
        else $error("two ports claim one slot");

    // Quiet data bus whenever the adapter is not driving.
    assert_quiet_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> (rdata == '0))
        else $error("data present while not driving");
endmodule

// File: rtl/dual_port_io.sv
// Module: top of the dual 8-bit parallel I/O adapter with its address
// decode glue. Port index 0 is Port B and index 1 is Port A, so the
// slot order 0..3 is B level, A level, B dir, A dir.
// Assumes a single synchronous clock with all bus inputs stable at its edge.
module dual_port_io #(
    parameter int ADDR_W     = 16,
    parameter int PORT_W     = 8,
    parameter int HI_SEL_BIT = 14,
    parameter int LO_SEL_BIT = 15,
    parameter int ROM_BIT    = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rw,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              rom_ce_n,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic [PORT_W-1:0] pa_oe,
    input  logic [PORT_W-1:0] pb_in,
    output logic [PORT_W-1:0] pb_out,
    output logic [PORT_W-1:0] pb_oe
);
    import pio_pkg::*;

    localparam int NPORT = 2;

    logic                          cs_hi;
    logic                          cs_lo_n;
    logic [REG_SEL_W-1:0]          reg_idx;
    logic                          wr_en;
    logic [NPORT-1:0]              rd_hit;
    logic [NPORT-1:0][PORT_W-1:0]  rd_val;
    logic [NPORT-1:0][PORT_W-1:0]  pin_in;
    logic [NPORT-1:0][PORT_W-1:0]  pin_out;
    logic [NPORT-1:0][PORT_W-1:0]  pin_oe;

    pio_addr_decode #(
        .ADDR_W(ADDR_W), .HI_SEL_BIT(HI_SEL_BIT), .LO_SEL_BIT(LO_SEL_BIT),
        .ROM_BIT(ROM_BIT), .SEL_W(REG_SEL_W)
    ) u_decode (
        .addr(addr), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
        .rom_ce_n(rom_ce_n), .reg_idx(reg_idx)
    );

    pio_bus_if #(.W(PORT_W), .NPORT(NPORT), .SEL_W(REG_SEL_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .rw(rw),
        .reg_idx(reg_idx), .rd_hit(rd_hit), .rd_val(rd_val),
        .wr_en(wr_en), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    // Pin mapping between named ports and the port array.
    always_comb begin
        pin_in[0] = pb_in;
        pin_in[1] = pa_in;
        pb_out    = pin_out[0];
        pb_oe     = pin_oe[0];
        pa_out    = pin_out[1];
        pa_oe     = pin_oe[1];
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        pio_port #(
            .W(PORT_W), .SEL_W(REG_SEL_W),
            .DATA_OFS(p), .DIR_OFS(p + NPORT)
        ) u_port (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_idx(reg_idx),
            .wdata(wdata), .pin_in(pin_in[p]), .pin_out(pin_out[p]),
            .pin_oe(pin_oe[p]), .rd_hit(rd_hit[p]), .rd_val(rd_val[p])
        );
    end

    // ROM space never enables the adapter's bus drive.
    assert_rom_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_ce_n |-> !rdata_oe)
        else $error("adapter drives bus in ROM space");

    // Writes outside the adapter's range leave every port register unchanged.
    assert_outside_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs_hi && !cs_lo_n) |=> ($stable(pa_out) && $stable(pa_oe) && $stable(pb_out) && $stable(pb_oe)))
        else $error("port changed by unselected cycle");

    // The drive enable never rises on a write cycle.
    assert_oe_read_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> rw)
        else $error("drive enable on write cycle");
endmodule

// File: tb/dual_port_io_tb.sv
`timescale 1ns/100ps
module dual_port_io_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        rw = 1'b1;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  pa_in = 8'h00;
    logic [7:0]  pb_in = 8'h00;
    logic [7:0]  rdata, pa_out, pa_oe, pb_out, pb_oe;
    logic        rdata_oe, rom_ce_n;

    int total = 0;
    int bad   = 0;

    // Model state, index 0 = Port B, 1 = Port A.
    logic [7:0] m_lvl [2];
    logic [7:0] m_dir [2];
    logic [7:0] m_smp [2];

    always #2.5 clk = ~clk;

    dual_port_io u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rw(rw), .wdata(wdata),
        .rdata(rdata), .rdata_oe(rdata_oe), .rom_ce_n(rom_ce_n),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit f_sel(input logic [15:0] a);
        return a[14] && !a[15];
    endfunction

    function automatic logic [7:0] f_mix(input int p);
        return (m_lvl[p] & m_dir[p]) | (m_smp[p] & ~m_dir[p]);
    endfunction

    function automatic logic [7:0] f_read(input logic [15:0] a, input bit r);
        if (!(f_sel(a) && r)) return 8'h00;
        case (a[3:0])
            4'd0: return f_mix(0);
            4'd1: return f_mix(1);
            4'd2: return m_dir[0];
            4'd3: return m_dir[1];
            default: return 8'h00;
        endcase
    endfunction

    task automatic check_pins(input string req);
        chk(pa_out === m_lvl[1], req, "pa_out", int'(pa_out), int'(m_lvl[1]));
        chk(pa_oe  === m_dir[1], req, "pa_oe",  int'(pa_oe),  int'(m_dir[1]));
        chk(pb_out === m_lvl[0], req, "pb_out", int'(pb_out), int'(m_lvl[0]));
        chk(pb_oe  === m_dir[0], req, "pb_oe",  int'(pb_oe),  int'(m_dir[0]));
    endtask

    // One bus cycle: drive at negedge, check combinational outputs,
    // commit the model at posedge, then check the port pins.
    task automatic access(input logic [15:0] a, input bit r, input logic [7:0] d,
                          input logic [7:0] pa_v, input logic [7:0] pb_v,
                          input string req);
        @(negedge clk);
        addr = a; rw = r; wdata = d; pa_in = pa_v; pb_in = pb_v;
        #1;
        chk(rdata_oe === (f_sel(a) && r), "R11", "rdata_oe", int'(rdata_oe), int'(f_sel(a) && r));
        chk(rdata === f_read(a, r), req, "rdata", int'(rdata), int'(f_read(a, r)));
        chk(rom_ce_n === !a[15], "R2", "rom_ce_n", int'(rom_ce_n), int'(!a[15]));
        @(posedge clk);
        if (f_sel(a) && !r) begin
            case (a[3:0])
                4'd0: m_lvl[0] = d;
                4'd1: m_lvl[1] = d;
                4'd2: m_dir[0] = d;
                4'd3: m_dir[1] = d;
                default: ;
            endcase
        end
        m_smp[0] = pb_v;
        m_smp[1] = pa_v;
        #1;
        check_pins(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rw = 1'b1; addr = 16'h4003; wdata = 8'hFF;
        repeat (2) @(posedge clk);
        for (int p = 0; p < 2; p++) begin
            m_lvl[p] = 8'h00; m_dir[p] = 8'h00; m_smp[p] = 8'h00;
        end
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_pins("R8");
    endtask

    initial begin
        #(1ms);
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        pa_in = 8'hFF; pb_in = 8'hFF;
        do_reset();
        // Reset: reads show cleared registers.
        access(16'h4003, 1'b1, 8'h00, 8'h00, 8'h00, "R8");
        access(16'h4001, 1'b1, 8'h00, 8'h00, 8'h00, "R8");

        // Blink program: all Port A pins out, alternate two patterns.
        access(16'h4003, 1'b0, 8'hFF, 8'h00, 8'h00, "R4");
        for (int i = 0; i < 3; i++) begin
            access(16'h4001, 1'b0, 8'h02, 8'h00, 8'h00, "R5");
            access(16'h4001, 1'b0, 8'h05, 8'h00, 8'h00, "R5");
        end
        access(16'h4001, 1'b1, 8'h00, 8'hAA, 8'h00, "R9");

        // Mirrors across the range.
        access(16'h7FF3, 1'b1, 8'h00, 8'h00, 8'h00, "R3");
        access(16'h5A61, 1'b0, 8'hA5, 8'h00, 8'h00, "R3");
        access(16'h4001, 1'b1, 8'h00, 8'h00, 8'h00, "R3");

        // Port B slots and mixed direction read-back.
        access(16'h4002, 1'b0, 8'h0F, 8'h00, 8'h5A, "R6");
        access(16'h4000, 1'b0, 8'h3C, 8'h00, 8'hC3, "R6");
        access(16'h4000, 1'b1, 8'h00, 8'h00, 8'h96, "R9");
        access(16'h4000, 1'b1, 8'h00, 8'h00, 8'h00, "R9");
        access(16'h4002, 1'b1, 8'h00, 8'h00, 8'h00, "R10");
        access(16'h6FF3, 1'b1, 8'h00, 8'h00, 8'h00, "R10");

        // Writes outside the adapter range and on read cycles.
        access(16'h8003, 1'b0, 8'h00, 8'h00, 8'h00, "R1");
        access(16'hC001, 1'b0, 8'h77, 8'h00, 8'h00, "R1");
        access(16'h0003, 1'b0, 8'h00, 8'h00, 8'h00, "R1");
        access(16'h3FF0, 1'b0, 8'h11, 8'h00, 8'h00, "R1");
        access(16'hFFFC, 1'b1, 8'h00, 8'h00, 8'h00, "R2");
        access(16'h4003, 1'b1, 8'h00, 8'h00, 8'h00, "R7");

        // Empty slots.
        for (int s = 4; s < 16; s++) begin
            access(16'h4000 | 16'(s), 1'b0, 8'hFF, 8'h00, 8'h00, "R12");
            access(16'h4000 | 16'(s), 1'b1, 8'h00, 8'hFF, 8'hFF, "R12");
        end

        // Constrained random traffic.
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a;
            int region = $urandom_range(0, 7);
            if (region < 5) begin
                a = 16'h4000 | 16'($urandom_range(0, 16'h3FFF));
                if ($urandom_range(0, 9) < 7) a[3:0] = 4'($urandom_range(0, 3));
            end else if (region == 5) begin
                a = 16'h8000 | 16'($urandom_range(0, 16'h7FFF));
            end else begin
                a = 16'($urandom_range(0, 16'h3FFF));
            end
            access(a, 1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)),
                   8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)), "R9");
        end

        // Mid-run reset.
        do_reset();
        access(16'h4002, 1'b1, 8'h00, 8'h00, 8'h00, "R8");
        access(16'h4000, 1'b1, 8'h00, 8'h00, 8'h00, "R8");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule